// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block takes a wide vector of system event lines, conditions each one by a programmable polarity and capture type, and latches it as a pending status bit. Each pending bit is gated by its own enable and is steered through a programmable map to one of a small set of priority channels. Channel 0 has the highest priority. Each channel is then steered to one host interrupt line. A global enable and per-host enables gate those lines.

Software finds out what to service by reading a single index register. It returns the number of the most urgent pending enabled event, or a flag when nothing is pending. When nesting is turned on, that read marks the winning channel as in service. The winning channel and every channel of lower priority are then held off the hosts until software clears an event of that channel, so only more urgent channels can interrupt the service routine. Status bits and enable bits are set or cleared one at a time by writing an event number to dedicated index registers. Mask writes are not used for them.

Access is through a simple word-addressed register port. Writes take effect at the clock edge. Read data is combinational.

Top module: `nest_intc`

## Requirements
- R1: After reset all status bits, enables, host enables, polarity and type bits are zero, the control word (word 0x000) reads 0, the priority index register (word 0x00A) reads 0x8000_0000, the nesting level register (word 0x001) reads NUM_CH (10), and host_o is 0.
- R2: A level-type event is captured into raw status (word 0x040 + N/32, bit N%32) while its conditioned input is active. It stays set after the input goes inactive, until it is cleared by writing N to the status-clear index register (word 0x005).
- R3: Polarity word 0x070 + N/32, bit N%32, set to 1 makes event N active-low. Set to 0 makes it active-high.
- R4: Type word 0x078 + N/32, bit N%32, set to 1 makes event N capture on a rising edge of the conditioned input. Such a bit cleared while the input is held active stays clear. A level-type bit cleared while its input is held active is set again.
- R5: Writing N to the status-set index register (word 0x004) sets raw status bit N. Writing N to the status-clear index register (word 0x005) clears it.
- R6: Writing N to word 0x006 sets enable bit N, and writing N to word 0x007 clears it. The enable words (0x060 + k) read back the enables. The enabled-status words (0x050 + k) read raw status AND enable.
- R7: The channel of event N is byte N%4 of map word 0x100 + N/4. Values 0 to 9 select a channel, and any other value routes the event nowhere.
- R8: The priority index register returns the number of the pending enabled event in the lowest-numbered unmasked channel, taking the lowest event number within that channel. With no such event it reads 0x8000_0000.
- R9: The host line of channel c is byte c%4 of word 0x180 + c/4. host_o[h] is high one cycle after any unmasked channel mapped to host h has a pending enabled event, but only when control bit 0 (global host enable) is 1 and host-enable bit h is set. Host-enable bits are set by writing h to word 0x008, cleared by writing h to word 0x009, and read at word 0x00B.
- R10: With control bit 1 (nesting) set, a read of the priority index register that returns an event marks that event's channel as in service. The marked channel and every higher-numbered channel are masked from the hosts and from the priority index register. The mark is removed when an event mapped to that channel is written to the status-clear index register. More urgent channels still reach the hosts.
- R11: The nesting level register reads the lowest in-service channel number, or NUM_CH when no channel is in service. Clearing control bit 1 drops all in-service marks.
- R12: Index writes with a value at or above the event count (or the host count, for the host-enable registers) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Raw system event lines |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (needed for the read side effect under nesting) |
| bus_addr_i | input | 10 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational on the address |
| host_o | output | NUM_HOST | Host interrupt lines, registered |

## Verification
A stuck or lost status bit shows up at once in the raw and enabled status words, and it shows on the mapped host line one cycle later. A wrong channel or host map entry sends an interrupt to the wrong host, or makes the priority index name the wrong event on the very next read. A nesting mark that is never released keeps host lines quiet and the level register below NUM_CH. The directed scenarios look for exactly these symptoms after each set, clear, map and service step.

// File: rtl/nest_intc_pkg.sv
package nest_intc_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned FLD_W  = 8;
  typedef logic [ADDR_W-1:0] waddr_t;

  localparam waddr_t A_CTRL     = 10'h000;
  localparam waddr_t A_NEST     = 10'h001;
  localparam waddr_t A_STAT_SET = 10'h004;
  localparam waddr_t A_STAT_CLR = 10'h005;
  localparam waddr_t A_EN_SET   = 10'h006;
  localparam waddr_t A_EN_CLR   = 10'h007;
  localparam waddr_t A_HEN_SET  = 10'h008;
  localparam waddr_t A_HEN_CLR  = 10'h009;
  localparam waddr_t A_PRI      = 10'h00A;
  localparam waddr_t A_HEN      = 10'h00B;
  localparam waddr_t A_RAW      = 10'h040;
  localparam waddr_t A_ENA      = 10'h050;
  localparam waddr_t A_EN       = 10'h060;
  localparam waddr_t A_POL      = 10'h070;
  localparam waddr_t A_TYPE     = 10'h078;
  localparam waddr_t A_MAP      = 10'h100;
  localparam waddr_t A_HMAP     = 10'h180;

  localparam logic [31:0] PRI_NONE = 32'h8000_0000;
endpackage

// File: rtl/nest_intc_latch.sv
module nest_intc_latch #(
  parameter int unsigned NUM_EVT = 160
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] pol_i,
  input  logic [NUM_EVT-1:0] type_i,
  input  logic [NUM_EVT-1:0] sw_set_i,
  input  logic [NUM_EVT-1:0] sw_clr_i,
  output logic [NUM_EVT-1:0] raw_o
);
  logic [NUM_EVT-1:0] cond, prev_q, raw_q, hw_set;

  assign cond   = evt_i ^ pol_i;
  // edge type: new activity only; level type: any activity
  assign hw_set = (type_i & cond & ~prev_q) | (~type_i & cond);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= cond;
      raw_q  <= (raw_q & ~sw_clr_i) | hw_set | sw_set_i;
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/nest_intc_route.sv
module nest_intc_route
  import nest_intc_pkg::*;
#(
  parameter int unsigned NUM_EVT = 160,
  parameter int unsigned NUM_CH  = 10,
  parameter int unsigned EVT_W   = 8
) (
  input  logic [NUM_EVT-1:0] ena_i,
  input  logic [FLD_W-1:0]   map_i [NUM_EVT],
  output logic [NUM_CH-1:0]  pend_o,
  output logic [EVT_W-1:0]   evt_o [NUM_CH]
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             p;
    logic [EVT_W-1:0] e;
    always_comb begin
      p = 1'b0;
      e = '0;
      // descending scan: lowest event number is taken last
      for (int i = NUM_EVT - 1; i >= 0; i--) begin
        if (ena_i[i] && map_i[i] == FLD_W'(c)) begin
          p = 1'b1;
          e = EVT_W'(i);
        end
      end
    end
    assign pend_o[c] = p;
    assign evt_o[c]  = e;
  end
endmodule

// File: rtl/nest_intc_nest.sv
module nest_intc_nest
  import nest_intc_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned CH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nest_en_i,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic              ack_i,
  input  logic [CH_W-1:0]   ack_ch_i,
  input  logic              done_i,
  input  logic [FLD_W-1:0]  done_ch_i,
  output logic [NUM_CH-1:0] allowed_o,
  output logic              win_valid_o,
  output logic [CH_W-1:0]   win_ch_o,
  output logic [CH_W-1:0]   level_o
);
  logic [NUM_CH-1:0] in_svc_q, blocked, live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_svc_q <= '0;
    end else if (!nest_en_i) begin
      in_svc_q <= '0;
    end else begin
      if (ack_i) in_svc_q[ack_ch_i] <= 1'b1;
      if (done_i && done_ch_i < FLD_W'(NUM_CH)) in_svc_q[done_ch_i[CH_W-1:0]] <= 1'b0;
    end
  end

  // a channel is blocked by itself and by any more urgent one in service
  always_comb begin
    logic run;
    run = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      run        = run | in_svc_q[k];
      blocked[k] = run;
    end
  end

  assign allowed_o = nest_en_i ? ~blocked : '1;
  assign live      = pend_i & allowed_o;

  always_comb begin
    win_valid_o = 1'b0;
    win_ch_o    = '0;
    level_o     = CH_W'(NUM_CH);
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (live[k]) begin
        win_valid_o = 1'b1;
        win_ch_o    = CH_W'(k);
      end
      if (in_svc_q[k]) level_o = CH_W'(k);
    end
  end
endmodule

// File: rtl/nest_intc.sv
module nest_intc
  import nest_intc_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 160,
  parameter int unsigned NUM_CH   = 10,
  parameter int unsigned NUM_HOST = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic                bus_we_i,
  input  logic                bus_re_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic [NUM_HOST-1:0] host_o
);
  localparam int unsigned EVT_W  = $clog2(NUM_EVT);
  localparam int unsigned CH_W   = $clog2(NUM_CH + 1);
  localparam int unsigned HOST_W = (NUM_HOST > 1) ? $clog2(NUM_HOST) : 1;

  logic [1:0]          ctrl_q;
  logic [NUM_EVT-1:0]  en_q, pol_q, type_q, raw_vec, ena_vec, sw_set, sw_clr;
  logic [NUM_HOST-1:0] hen_q, host_q, host_req;
  logic [FLD_W-1:0]    map_q  [NUM_EVT];
  logic [FLD_W-1:0]    hmap_q [NUM_CH];
  logic [NUM_CH-1:0]   ch_pend, allowed;
  logic [EVT_W-1:0]    ch_evt [NUM_CH];
  logic                win_valid, ack, done, idx_ok, hidx_ok;
  logic [CH_W-1:0]     win_ch, nest_level;
  logic [EVT_W-1:0]    idx, pri_evt;
  logic [HOST_W-1:0]   hidx;
  logic [31:0]         pri_word;

  assign idx_ok  = bus_wdata_i < 32'(NUM_EVT);
  assign hidx_ok = bus_wdata_i < 32'(NUM_HOST);
  assign idx     = bus_wdata_i[EVT_W-1:0];
  assign hidx    = bus_wdata_i[HOST_W-1:0];

  always_comb begin
    sw_set = '0;
    sw_clr = '0;
    if (bus_we_i && idx_ok && bus_addr_i == A_STAT_SET) sw_set[idx] = 1'b1;
    if (bus_we_i && idx_ok && bus_addr_i == A_STAT_CLR) sw_clr[idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      en_q   <= '0;
      hen_q  <= '0;
      pol_q  <= '0;
      type_q <= '0;
      for (int i = 0; i < NUM_EVT; i++) map_q[i] <= '0;
      for (int c = 0; c < NUM_CH; c++) hmap_q[c] <= '0;
    end else if (bus_we_i) begin
      if (bus_addr_i == A_CTRL) ctrl_q <= bus_wdata_i[1:0];
      if (idx_ok && bus_addr_i == A_EN_SET) en_q[idx] <= 1'b1;
      if (idx_ok && bus_addr_i == A_EN_CLR) en_q[idx] <= 1'b0;
      if (hidx_ok && bus_addr_i == A_HEN_SET) hen_q[hidx] <= 1'b1;
      if (hidx_ok && bus_addr_i == A_HEN_CLR) hen_q[hidx] <= 1'b0;
      for (int i = 0; i < NUM_EVT; i++) begin
        if (bus_addr_i == A_POL + waddr_t'(i / 32)) pol_q[i] <= bus_wdata_i[i % 32];
        if (bus_addr_i == A_TYPE + waddr_t'(i / 32)) type_q[i] <= bus_wdata_i[i % 32];
        if (bus_addr_i == A_MAP + waddr_t'(i / 4)) map_q[i] <= bus_wdata_i[(i % 4)*FLD_W +: FLD_W];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_addr_i == A_HMAP + waddr_t'(c / 4)) hmap_q[c] <= bus_wdata_i[(c % 4)*FLD_W +: FLD_W];
      end
    end
  end

  nest_intc_latch #(.NUM_EVT(NUM_EVT)) i_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .pol_i    (pol_q),
    .type_i   (type_q),
    .sw_set_i (sw_set),
    .sw_clr_i (sw_clr),
    .raw_o    (raw_vec)
  );

  assign ena_vec = raw_vec & en_q;

  nest_intc_route #(.NUM_EVT(NUM_EVT), .NUM_CH(NUM_CH), .EVT_W(EVT_W)) i_route (
    .ena_i  (ena_vec),
    .map_i  (map_q),
    .pend_o (ch_pend),
    .evt_o  (ch_evt)
  );

  assign ack  = bus_re_i && bus_addr_i == A_PRI && win_valid;
  assign done = bus_we_i && idx_ok && bus_addr_i == A_STAT_CLR;

  nest_intc_nest #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_nest (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nest_en_i   (ctrl_q[1]),
    .pend_i      (ch_pend),
    .ack_i       (ack),
    .ack_ch_i    (win_ch),
    .done_i      (done),
    .done_ch_i   (map_q[idx]),
    .allowed_o   (allowed),
    .win_valid_o (win_valid),
    .win_ch_o    (win_ch),
    .level_o     (nest_level)
  );

  assign pri_evt  = ch_evt[win_ch];
  assign pri_word = win_valid ? 32'(pri_evt) : PRI_NONE;

  always_comb begin
    host_req = '0;
    for (int h = 0; h < NUM_HOST; h++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (hmap_q[c] == FLD_W'(h) && ch_pend[c] && allowed[c]) host_req[h] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_q <= '0;
    else         host_q <= ctrl_q[0] ? (hen_q & host_req) : '0;
  end

  assign host_o = host_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_CTRL) bus_rdata_o = 32'(ctrl_q);
    if (bus_addr_i == A_NEST) bus_rdata_o = 32'(nest_level);
    if (bus_addr_i == A_PRI)  bus_rdata_o = pri_word;
    if (bus_addr_i == A_HEN)  bus_rdata_o = 32'(hen_q);
    for (int i = 0; i < NUM_EVT; i++) begin
      if (bus_addr_i == A_RAW  + waddr_t'(i / 32)) bus_rdata_o[i % 32] = raw_vec[i];
      if (bus_addr_i == A_ENA  + waddr_t'(i / 32)) bus_rdata_o[i % 32] = ena_vec[i];
      if (bus_addr_i == A_EN   + waddr_t'(i / 32)) bus_rdata_o[i % 32] = en_q[i];
      if (bus_addr_i == A_POL  + waddr_t'(i / 32)) bus_rdata_o[i % 32] = pol_q[i];
      if (bus_addr_i == A_TYPE + waddr_t'(i / 32)) bus_rdata_o[i % 32] = type_q[i];
      if (bus_addr_i == A_MAP  + waddr_t'(i / 4))  bus_rdata_o[(i % 4)*FLD_W +: FLD_W] = map_q[i];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr_i == A_HMAP + waddr_t'(c / 4)) bus_rdata_o[(c % 4)*FLD_W +: FLD_W] = hmap_q[c];
    end
  end
endmodule

// File: rtl/nest_intc_chk.sv
module nest_intc_chk
  import nest_intc_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 160,
  parameter int unsigned NUM_CH   = 10,
  parameter int unsigned NUM_HOST = 10
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        bus_we_i,
  input logic [ADDR_W-1:0]           bus_addr_i,
  input logic [NUM_EVT-1:0]          raw_i,
  input logic [NUM_EVT-1:0]          en_i,
  input logic                        pri_valid_i,
  input logic [$clog2(NUM_EVT)-1:0]  pri_evt_i,
  input logic                        glb_en_i,
  input logic                        nest_en_i,
  input logic [NUM_HOST-1:0]         hen_i,
  input logic [NUM_HOST-1:0]         host_i,
  input logic [$clog2(NUM_CH+1)-1:0] level_i,
  input logic [FLD_W-1:0]            map_i [NUM_EVT]
);
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == A_STAT_CLR) |=> (($past(raw_i) & ~raw_i) == '0)); // R2

  AST_PRI_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_valid_i |-> (en_i[pri_evt_i] && raw_i[pri_evt_i])); // R6

  AST_PRI_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_i & en_i) == '0) |-> !pri_valid_i); // R8

  AST_HOST_GLOBAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> (host_i == '0)); // R9

  AST_HOST_ENABLE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((host_i & ~$past(hen_i)) == '0)); // R9

  AST_NEST_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nest_en_i && pri_valid_i) |-> (map_i[pri_evt_i] < FLD_W'(level_i))); // R10

  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= ($clog2(NUM_CH+1))'(NUM_CH)); // R11
endmodule

bind nest_intc nest_intc_chk #(
  .NUM_EVT(NUM_EVT), .NUM_CH(NUM_CH), .NUM_HOST(NUM_HOST)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .raw_i       (raw_vec),
  .en_i        (en_q),
  .pri_valid_i (win_valid),
  .pri_evt_i   (pri_evt),
  .glb_en_i    (ctrl_q[0]),
  .nest_en_i   (ctrl_q[1]),
  .hen_i       (hen_q),
  .host_i      (host_o),
  .level_i     (nest_level),
  .map_i       (map_q)
);

// File: tb/test_nest_intc.sv
`timescale 1ns/1ps
module test_nest_intc;
  localparam int unsigned NE = 160;
  localparam int unsigned NH = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NH-1:0] host;
  int            n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  nest_intc #(.NUM_EVT(NE), .NUM_CH(10), .NUM_HOST(NH)) i_nest_intc (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .host_o(host)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a; re = 1'b1;
    #1 chk(req, rdata, exp);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic host_chk(input string req, input logic [31:0] exp);
    tick(2);
    chk(req, 32'(host), exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 10'h000, 32'h0);
    rd_chk("R1 pri", 10'h00A, 32'h8000_0000);
    rd_chk("R1 nest", 10'h001, 32'd10);
    rd_chk("R1 raw0", 10'h040, 32'h0);
    rd_chk("R1 en4", 10'h064, 32'h0);
    chk("R1 host", 32'(host), 32'h0);
  endtask

  task automatic t_level;
    @(negedge clk) evt[5] = 1'b1; evt[37] = 1'b1;
    tick(2);
    rd_chk("R2 raw0 set", 10'h040, 32'h20);
    rd_chk("R2 raw1 set", 10'h041, 32'h20);
    @(negedge clk) evt[5] = 1'b0; evt[37] = 1'b0;
    tick(2);
    rd_chk("R2 raw0 held", 10'h040, 32'h20);
    wr(10'h005, 32'd5);
    wr(10'h005, 32'd37);
    rd_chk("R2 raw0 cleared", 10'h040, 32'h0);
    rd_chk("R2 raw1 cleared", 10'h041, 32'h0);
  endtask

  task automatic t_polarity;
    wr(10'h070, 32'h8);
    tick(1);
    rd_chk("R3 active low idle sets", 10'h040, 32'h8);
    @(negedge clk) evt[3] = 1'b1;
    wr(10'h005, 32'd3);
    tick(1);
    rd_chk("R3 high is inactive", 10'h040, 32'h0);
    @(negedge clk) evt[3] = 1'b0;
    wr(10'h070, 32'h0);
    wr(10'h005, 32'd3);
    tick(1);
    rd_chk("R3 active high low idle", 10'h040, 32'h0);
  endtask

  task automatic t_edge;
    wr(10'h078, 32'h80);
    @(negedge clk) evt[7] = 1'b1; evt[9] = 1'b1;
    tick(2);
    rd_chk("R4 both captured", 10'h040, 32'h280);
    wr(10'h005, 32'd7);
    wr(10'h005, 32'd9);
    tick(1);
    rd_chk("R4 edge stays clear, level re-sets", 10'h040, 32'h200);
    @(negedge clk) evt[7] = 1'b0; evt[9] = 1'b0;
    wr(10'h005, 32'd9);
    @(negedge clk) evt[7] = 1'b1;
    tick(2);
    rd_chk("R4 new edge captured", 10'h040, 32'h80);
    @(negedge clk) evt[7] = 1'b0;
    wr(10'h005, 32'd7);
    wr(10'h078, 32'h0);
    rd_chk("R4 cleanup", 10'h040, 32'h0);
  endtask

  task automatic t_index;
    wr(10'h004, 32'd100);
    rd_chk("R5 set index", 10'h043, 32'h10);
    wr(10'h004, 32'd200);
    wr(10'h006, 32'd160);
    wr(10'h008, 32'd10);
    rd_chk("R12 set ignored raw3", 10'h043, 32'h10);
    rd_chk("R12 set ignored raw4", 10'h044, 32'h0);
    rd_chk("R12 en ignored", 10'h064, 32'h0);
    rd_chk("R12 hen ignored", 10'h00B, 32'h0);
    wr(10'h005, 32'd300);
    rd_chk("R12 clr ignored", 10'h043, 32'h10);
    wr(10'h005, 32'd100);
    rd_chk("R5 clr index", 10'h043, 32'h0);
  endtask

  task automatic t_enable;
    wr(10'h004, 32'd40);
    rd_chk("R6 not enabled", 10'h051, 32'h0);
    wr(10'h006, 32'd40);
    rd_chk("R6 en word", 10'h061, 32'h100);
    rd_chk("R6 ena word", 10'h051, 32'h100);
    wr(10'h007, 32'd40);
    rd_chk("R6 ena after clr", 10'h051, 32'h0);
    rd_chk("R6 raw kept", 10'h041, 32'h100);
    wr(10'h005, 32'd40);
  endtask

  task automatic t_priority;
    wr(10'h10C, 32'h0003_0000);   // event 50 -> ch3
    wr(10'h105, 32'h0000_0003);   // event 20 -> ch3
    wr(10'h120, 32'h0001_0000);   // event 130 -> ch1
    rd_chk("R7 map readback", 10'h120, 32'h0001_0000);
    wr(10'h006, 32'd50); wr(10'h006, 32'd20); wr(10'h006, 32'd130);
    wr(10'h004, 32'd50);
    rd_chk("R8 single", 10'h00A, 32'd50);
    wr(10'h004, 32'd20);
    rd_chk("R8 lowest in channel", 10'h00A, 32'd20);
    wr(10'h004, 32'd130);
    rd_chk("R8 urgent channel wins", 10'h00A, 32'd130);
    wr(10'h120, 32'h000C_0000);   // event 130 -> 12: no channel
    rd_chk("R7 out of range map", 10'h00A, 32'd20);
    wr(10'h120, 32'h0001_0000);
    wr(10'h005, 32'd50); wr(10'h005, 32'd20); wr(10'h005, 32'd130);
    rd_chk("R8 none pending", 10'h00A, 32'h8000_0000);
  endtask

  task automatic t_host;
    wr(10'h180, 32'h0200_0000);   // ch3 -> host2, others host0
    wr(10'h004, 32'd20);
    host_chk("R9 global off", 32'h0);
    wr(10'h000, 32'h1);
    host_chk("R9 host not enabled", 32'h0);
    wr(10'h008, 32'd2);
    host_chk("R9 host2", 32'h4);
    wr(10'h008, 32'd0);
    wr(10'h004, 32'd130);
    host_chk("R9 two hosts", 32'h5);
    wr(10'h009, 32'd2);
    host_chk("R9 host2 disabled", 32'h1);
    rd_chk("R9 hen readback", 10'h00B, 32'h1);
    wr(10'h005, 32'd20); wr(10'h005, 32'd130);
    host_chk("R9 idle", 32'h0);
  endtask

  task automatic t_nest;
    wr(10'h008, 32'd2);
    wr(10'h000, 32'h3);
    wr(10'h004, 32'd20);
    host_chk("R10 ch3 before service", 32'h4);
    rd_chk("R10 pri ch3", 10'h00A, 32'd20);
    rd_chk("R11 level 3", 10'h001, 32'd3);
    host_chk("R10 ch3 masked", 32'h0);
    rd_chk("R10 pri masked", 10'h00A, 32'h8000_0000);
    wr(10'h004, 32'd130);
    host_chk("R10 urgent passes", 32'h1);
    rd_chk("R10 pri nested", 10'h00A, 32'd130);
    rd_chk("R11 level 1", 10'h001, 32'd1);
    host_chk("R10 ch1 masked", 32'h0);
    wr(10'h005, 32'd130);
    rd_chk("R11 back to 3", 10'h001, 32'd3);
    host_chk("R10 ch3 still masked", 32'h0);
    wr(10'h005, 32'd20);
    rd_chk("R11 none in service", 10'h001, 32'd10);
    wr(10'h004, 32'd20);
    host_chk("R10 ch3 unmasked", 32'h4);
    rd_chk("R10 mark again", 10'h00A, 32'd20);
    wr(10'h000, 32'h1);
    rd_chk("R11 nest off drops marks", 10'h001, 32'd10);
    rd_chk("R11 no mark without nesting", 10'h00A, 32'd20);
    rd_chk("R11 still none", 10'h001, 32'd10);
    host_chk("R10 plain delivery", 32'h4);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_level();
    t_polarity();
    t_edge();
    t_index();
    t_enable();
    t_priority();
    t_host();
    t_nest();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule